// File: doc/BRIEF.md
# Position-Limit Managed Buffer Memory

This block is an on-chip store with a fixed number of elements. Four index registers govern access to it: capacity, limit, position and an optional mark. A client sends one command per clock on a small command port. The command carries an opcode, an index operand and a write value. Relative transfers use the current position and then advance it. Absolute transfers name their own index and leave position alone. Further commands reshape the window: clear, flip, rewind, mark, return-to-mark, set-position and set-limit.

The ordering mark ≤ position ≤ limit ≤ capacity holds at all times. A command that would break this ordering, or that is illegal for another reason, changes nothing. Such a command produces a non-zero error code for one cycle instead. A read-only input blocks every write into the store but leaves the index registers adjustable. Read data, the valid strobe and the error code are all registered. They show the result of a command on the cycle after it is accepted. The current position, the current limit and the mark-defined flag are also brought out, so a client can track the window.

Top module: `pos_limit_buffer`

## Requirements
- R1: After a synchronous reset, position is 0 and limit equals the capacity (DEPTH, 16 by default). No mark is defined, the error code is 0 and rd_valid is low.
- R2: Relative put (op 2) writes wdata at the current position and increments position. When position equals limit, it reports overflow (error 2) and stores nothing.
- R3: Relative get (op 1) returns the element at the current position on rd_data one cycle later, with rd_valid high, and increments position. When position equals limit, it reports underflow (error 1).
- R4: Absolute get (op 3) reads, and absolute put (op 4) writes, the element at idx without moving position. An idx at or above limit reports out-of-range (error 3) and transfers nothing.
- R5: Clear (op 5) sets limit to capacity and position to 0. Flip (op 6) sets limit to the old position and position to 0. Rewind (op 7) sets position to 0 and keeps limit.
- R6: Set-mark (op 8) records the current position as the mark. Return-to-mark (op 9) loads position from the mark. If no mark is defined, return-to-mark reports invalid-mark (error 4) instead.
- R7: Any command that leaves position or limit below a defined mark makes the mark undefined.
- R8: Set-position (op 10) loads idx. An idx above limit reports out-of-range (error 3). Set-limit (op 11) loads idx and pulls position down to idx when position is larger. An idx above capacity reports out-of-range (error 3).
- R9: While read_only is high, both puts report read-only (error 5). This check ranks ahead of the overflow and range checks. Gets and index commands still work normally.
- R10: A command that reports an error leaves position, limit, mark and the store unchanged, and its rd_valid is low. The error code is 0 on every cycle without a fault, including no-op (op 0) cycles.
- R11: The ordering mark ≤ position ≤ limit ≤ capacity holds on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Command opcode, 0 = no-op |
| idx | input | $clog2(DEPTH+1) | Index operand for absolute access, set-position and set-limit |
| wdata | input | DW | Value written by puts |
| read_only | input | 1 | Blocks all puts while high |
| rd_data | output | DW | Element returned by an accepted get |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's get |
| err_code | output | 3 | Fault code of the previous cycle's command, 0 when none |
| pos_o | output | $clog2(DEPTH+1) | Current position |
| lim_o | output | $clog2(DEPTH+1) | Current limit |
| mark_set_o | output | 1 | A mark is currently defined |

## Verification
The first pattern fills the store with relative puts, flips, and then drains it with relative gets until underflow. This separates correct position advance from an off-by-one at the limit. Absolute accesses are then mixed with the relative ones, which shows whether an absolute transfer disturbs position and whether the range check uses limit or capacity. A sequence of mark, move and return-to-mark is run, followed by moves below the mark. It tells a mark that is kept apart from one that is discarded. Toggling read_only around puts aimed at out-of-range indices exposes the order in which the error checks rank.

// File: rtl/plb_pkg.sv
`timescale 1ns/1ps
package plb_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_RGET   = 4'd1,
    OP_RPUT   = 4'd2,
    OP_AGET   = 4'd3,
    OP_APUT   = 4'd4,
    OP_CLEAR  = 4'd5,
    OP_FLIP   = 4'd6,
    OP_REWIND = 4'd7,
    OP_MARK   = 4'd8,
    OP_TOMARK = 4'd9,
    OP_SETPOS = 4'd10,
    OP_SETLIM = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_UNDER   = 3'd1,
    ERR_OVER    = 3'd2,
    ERR_RANGE   = 3'd3,
    ERR_NOMARK  = 3'd4,
    ERR_RDONLY  = 3'd5
  } err_e;

endpackage

// File: rtl/plb_store.sv
`timescale 1ns/1ps
module plb_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/plb_ctrl.sv
`timescale 1ns/1ps
module plb_ctrl
  import plb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_i,
  input  logic [IW-1:0] idx,
  input  logic          read_only,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          rd_valid,
  output logic [2:0]    err_code,
  output logic [IW-1:0] pos_o,
  output logic [IW-1:0] lim_o,
  output logic          mark_set_o
);

  localparam logic [IW-1:0] CAP = IW'(DEPTH);

  op_e           op;
  logic [IW-1:0] pos_q, lim_q, mark_q;
  logic          mdef_q;
  logic [IW-1:0] pos_n, lim_n, mark_n;
  logic          mdef_n;
  err_e          err_n, err_q;
  logic          rv_n, rv_q;
  logic [IW-1:0] addr_n;

  assign op = op_e'(op_i);

  always_comb begin
    pos_n  = pos_q;
    lim_n  = lim_q;
    mark_n = mark_q;
    mdef_n = mdef_q;
    err_n  = ERR_NONE;
    rv_n   = 1'b0;
    mem_we = 1'b0;
    addr_n = pos_q;
    case (op)
      OP_RGET: begin
        if (pos_q >= lim_q) err_n = ERR_UNDER;
        else begin
          rv_n  = 1'b1;
          pos_n = pos_q + IW'(1);
        end
      end
      OP_RPUT: begin
        if (read_only)           err_n = ERR_RDONLY;
        else if (pos_q >= lim_q) err_n = ERR_OVER;
        else begin
          mem_we = 1'b1;
          pos_n  = pos_q + IW'(1);
        end
      end
      OP_AGET: begin
        addr_n = idx;
        if (idx >= lim_q) err_n = ERR_RANGE;
        else              rv_n  = 1'b1;
      end
      OP_APUT: begin
        addr_n = idx;
        if (read_only)         err_n  = ERR_RDONLY;
        else if (idx >= lim_q) err_n  = ERR_RANGE;
        else                   mem_we = 1'b1;
      end
      OP_CLEAR: begin
        lim_n = CAP;
        pos_n = '0;
      end
      OP_FLIP: begin
        lim_n = pos_q;
        pos_n = '0;
      end
      OP_REWIND: pos_n = '0;
      OP_MARK: begin
        mark_n = pos_q;
        mdef_n = 1'b1;
      end
      OP_TOMARK: begin
        if (!mdef_q) err_n = ERR_NOMARK;
        else         pos_n = mark_q;
      end
      OP_SETPOS: begin
        if (idx > lim_q) err_n = ERR_RANGE;
        else             pos_n = idx;
      end
      OP_SETLIM: begin
        if (idx > CAP) err_n = ERR_RANGE;
        else begin
          lim_n = idx;
          if (pos_q > idx) pos_n = idx;
        end
      end
      default: ;
    endcase
    // a mark left above the new position or limit is discarded
    if (mdef_n && ((pos_n < mark_n) || (lim_n < mark_n))) mdef_n = 1'b0;
  end

  assign mem_addr = addr_n[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      lim_q  <= CAP;
      mark_q <= '0;
      mdef_q <= 1'b0;
      err_q  <= ERR_NONE;
      rv_q   <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      lim_q  <= lim_n;
      mark_q <= mark_n;
      mdef_q <= mdef_n;
      err_q  <= err_n;
      rv_q   <= rv_n;
    end
  end

  assign rd_valid   = rv_q;
  assign err_code   = err_q;
  assign pos_o      = pos_q;
  assign lim_o      = lim_q;
  assign mark_set_o = mdef_q;

  // R11
  order_invariant_chk: assert property (@(posedge clk) disable iff (rst)
    (pos_q <= lim_q) && (lim_q <= CAP) && (!mdef_q || (mark_q <= pos_q)));

  // R10
  fault_freezes_state_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q != ERR_NONE) |-> ($stable(pos_q) && $stable(lim_q) && $stable(mdef_q) && !rv_q));

  // R3
  valid_after_get_chk: assert property (@(posedge clk) disable iff (rst)
    rv_q |-> ($past(!rst) && ($past(op) == OP_RGET || $past(op) == OP_AGET)));

  // R9
  readonly_put_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(read_only) && ($past(op) == OP_RPUT || $past(op) == OP_APUT))
      |-> (err_q == ERR_RDONLY));

  // R7
  mark_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(mdef_q) && (pos_q < $past(mark_q))) |-> !mdef_q);

endmodule

// File: rtl/pos_limit_buffer.sv
`timescale 1ns/1ps
module pos_limit_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  input  logic          read_only,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [2:0]    err_code,
  output logic [IW-1:0] pos_o,
  output logic [IW-1:0] lim_o,
  output logic          mark_set_o
);

  logic          mem_we;
  logic [AW-1:0] mem_addr;

  plb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op),
    .idx        (idx),
    .read_only  (read_only),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .rd_valid   (rd_valid),
    .err_code   (err_code),
    .pos_o      (pos_o),
    .lim_o      (lim_o),
    .mark_set_o (mark_set_o)
  );

  plb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (wdata),
    .rdata (rd_data)
  );

endmodule

// File: tb/tb_pos_limit_buffer.sv
`timescale 1ns/1ps
module tb_pos_limit_buffer;
  import plb_pkg::*;

  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int IW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op = '0;
  logic [IW-1:0] idx = '0;
  logic [DW-1:0] wdata = '0;
  logic          read_only = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [2:0]    err_code;
  logic [IW-1:0] pos_o, lim_o;
  logic          mark_set_o;

  always #2 clk = ~clk;

  pos_limit_buffer #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst(rst), .op(op), .idx(idx), .wdata(wdata), .read_only(read_only),
    .rd_data(rd_data), .rd_valid(rd_valid), .err_code(err_code),
    .pos_o(pos_o), .lim_o(lim_o), .mark_set_o(mark_set_o)
  );

  typedef struct {
    int    err;
    int    rv;
    int    data;
    int    pos;
    int    lim;
    int    mdef;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  int m_pos, m_lim, m_mark, m_mdef;
  int m_mem [DEPTH];

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model from the requirements, then drive and queue the expectation
  task automatic cmd(input op_e o, input int ix, input int wd, input bit ro, input string tag);
    exp_t e;
    int np = m_pos, nl = m_lim, nm = m_mark, nd = m_mdef;
    e.err = 0; e.rv = 0; e.data = 0; e.tag = tag;
    case (o)
      OP_RGET:   if (m_pos >= m_lim) e.err = 1; else begin e.rv = 1; e.data = m_mem[m_pos]; np = m_pos + 1; end
      OP_RPUT:   if (ro) e.err = 5; else if (m_pos >= m_lim) e.err = 2; else begin m_mem[m_pos] = wd; np = m_pos + 1; end
      OP_AGET:   if (ix >= m_lim) e.err = 3; else begin e.rv = 1; e.data = m_mem[ix]; end
      OP_APUT:   if (ro) e.err = 5; else if (ix >= m_lim) e.err = 3; else m_mem[ix] = wd;
      OP_CLEAR:  begin nl = DEPTH; np = 0; end
      OP_FLIP:   begin nl = m_pos; np = 0; end
      OP_REWIND: np = 0;
      OP_MARK:   begin nm = m_pos; nd = 1; end
      OP_TOMARK: if (m_mdef == 0) e.err = 4; else np = m_mark;
      OP_SETPOS: if (ix > m_lim) e.err = 3; else np = ix;
      OP_SETLIM: if (ix > DEPTH) e.err = 3; else begin nl = ix; if (m_pos > ix) np = ix; end
      default: ;
    endcase
    if (nd != 0 && (np < nm || nl < nm)) nd = 0;
    m_pos = np; m_lim = nl; m_mark = nm; m_mdef = nd;
    e.pos = np; e.lim = nl; e.mdef = nd;
    @(negedge clk);
    op = o; idx = IW'(ix); wdata = DW'(wd); read_only = ro;
    q.push_back(e);
  endtask

  // monitor: compare one cycle after each command is taken
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp(e.tag, "err_code", 32'(err_code), 32'(e.err));
      cmp(e.tag, "rd_valid", 32'(rd_valid), 32'(e.rv));
      if (e.rv != 0) cmp(e.tag, "rd_data", 32'(rd_data), 32'(e.data));
      cmp(e.tag, "pos", 32'(pos_o), 32'(e.pos));
      cmp(e.tag, "lim", 32'(lim_o), 32'(e.lim));
      cmp(e.tag, "mark_set", 32'(mark_set_o), 32'(e.mdef));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_pos = 0; m_lim = DEPTH; m_mark = 0; m_mdef = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cmp("R1", "pos", 32'(pos_o), 0);
    cmp("R1", "lim", 32'(lim_o), DEPTH);
    cmp("R1", "mark_set", 32'(mark_set_o), 0);
    cmp("R1", "err_code", 32'(err_code), 0);
    cmp("R1", "rd_valid", 32'(rd_valid), 0);

    cmd(OP_NOP, 0, 0, 0, "R10 nop");
    for (int i = 0; i < 4; i++) cmd(OP_RPUT, 0, 'hA0 + i, 0, "R2 fill");
    cmd(OP_FLIP, 0, 0, 0, "R5 flip");
    for (int i = 0; i < 4; i++) cmd(OP_RGET, 0, 0, 0, "R3 drain");
    cmd(OP_RGET, 0, 0, 0, "R3 underflow");
    cmd(OP_RPUT, 0, 'h11, 0, "R2 overflow");
    cmd(OP_REWIND, 0, 0, 0, "R5 rewind");
    cmd(OP_AGET, 2, 0, 0, "R4 abs get");
    cmd(OP_AGET, 4, 0, 0, "R4 abs range");
    cmd(OP_APUT, 1, 'h55, 0, "R4 abs put");
    cmd(OP_AGET, 1, 0, 0, "R4 abs readback");
    cmd(OP_SETPOS, 2, 0, 0, "R8 setpos");
    cmd(OP_MARK, 0, 0, 0, "R6 mark");
    cmd(OP_SETPOS, 3, 0, 0, "R8 setpos");
    cmd(OP_TOMARK, 0, 0, 0, "R6 to mark");
    cmd(OP_SETPOS, 1, 0, 0, "R7 below mark");
    cmd(OP_TOMARK, 0, 0, 0, "R6 no mark");
    cmd(OP_SETPOS, 5, 0, 0, "R8 pos range");
    cmd(OP_CLEAR, 0, 0, 0, "R5 clear");
    cmd(OP_SETPOS, 10, 0, 0, "R8 setpos");
    cmd(OP_MARK, 0, 0, 0, "R6 mark");
    cmd(OP_SETLIM, 8, 0, 0, "R7 R8 clamp");
    cmd(OP_SETLIM, DEPTH + 1, 0, 0, "R8 lim range");
    cmd(OP_SETLIM, DEPTH, 0, 0, "R8 lim cap");
    cmd(OP_RPUT, 0, 'h77, 1, "R9 rput ro");
    cmd(OP_APUT, 20, 'h77, 1, "R9 aput ro priority");
    cmd(OP_AGET, 0, 0, 1, "R9 get under ro");
    cmd(OP_SETPOS, 3, 0, 1, "R9 setpos under ro");
    cmd(OP_AGET, 3, 0, 0, "R9 R10 untouched");
    cmd(OP_RPUT, 0, 'h3C, 0, "R2 put");
    cmd(OP_AGET, 3, 0, 0, "R2 readback");
    cmd(OP_SETPOS, DEPTH, 0, 0, "R8 pos at cap");
    cmd(OP_RPUT, 0, 'h01, 0, "R2 full overflow");
    cmd(OP_NOP, 0, 0, 0, "R10 nop");
    @(negedge clk);
    op = OP_NOP;
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule